// File: doc/BRIEF.md
# Full-Tree Unsigned Multiplier with Selectable Column Compression

This block multiplies two unsigned operands of `N` bits (7 by default) and returns the full `2N`-bit product. All partial-product bits are formed at once by an AND array. A carry-save tree of full and half adders then squeezes each weighted column down to at most two bits. One carry-propagate adder adds the two surviving rows. Nothing in the datapath feeds back.

A parameter picks the compression schedule. The late schedule compresses a column only when it must, so that the column fits under the height limit of the next level. The limits grow as 2, 3, 4, 6, 9 and so on. The early schedule compresses every group of three bits, and every leftover pair, at each level. Both schedules finish in the same minimal number of levels, which is four for seven rows. A second parameter adds an output register stage. With that stage present the product appears one clock after the operands are sampled. Without it the product is purely combinational.

Top module: `mul_full_tree`

## Requirements
- R1: With the late schedule, `prod` equals the unsigned product `op_a * op_b` for every operand pair.
- R2: With the early schedule, `prod` equals the unsigned product `op_a * op_b` for every operand pair.
- R3: With `REG_OUT=1`, `prod` shows the product of the operands sampled at a rising edge of `clk` from that edge onward. Before that edge it still shows the previous result.
- R4: With `REG_OUT=1`, a high `rst` sampled at a rising edge forces `prod` to zero after that edge.
- R5: With `REG_OUT=0`, `prod` follows the operands with no clock edge involved.
- R6: Both schedules use the same number of reduction levels, and that number is the minimum given by the height-limit sequence 2, 3, 4, 6, 9, ... (four levels for 7 rows).
- R7: The corner operands give exact results: zero times anything is 0, 1 times x is x, and the all-ones pair gives (2^N-1)^2, which is 16129 for N=7.
- R8: While the operands are held constant, `prod` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| op_a | input | N | Multiplicand, unsigned |
| op_b | input | N | Multiplier, unsigned |
| prod | output | 2N | Unsigned product |

## Verification
The registered instance is due one rising edge after its operands are driven. The combinational instance is due within the same cycle. The bench drives on the falling edge and samples one time unit after the next rising edge, so both results are read where they are settled. For the latency check, the registered output is also read just before the capturing edge, where it must still hold the previous product. The reset check samples one edge after `rst` is raised, and the hold check samples across three edges with the operands frozen.

// File: rtl/mul_tree_pkg.sv
package mul_tree_pkg;

    typedef enum logic {
        POL_LATE  = 1'b0,
        POL_EARLY = 1'b1
    } policy_e;

    typedef struct packed {
        logic carry;
        logic sum;
    } csa_out_t;

    function automatic csa_out_t full_add(input logic x, input logic y, input logic z);
        csa_out_t r;
        r.sum   = x ^ y ^ z;
        r.carry = (x & y) | (x & z) | (y & z);
        return r;
    endfunction

    function automatic csa_out_t half_add(input logic x, input logic y);
        csa_out_t r;
        r.sum   = x ^ y;
        r.carry = x & y;
        return r;
    endfunction

    // Height bound allowed after a level: index 0 is the final bound of 2.
    function automatic int limit_at(input int idx);
        int d;
        d = 2;
        for (int i = 0; i < idx; i++) d = (d * 3) / 2;
        return d;
    endfunction

    // Minimal level count for a given number of rows.
    function automatic int late_levels(input int rows);
        int d;
        int cnt;
        d   = 2;
        cnt = 0;
        for (int i = 0; i < 32; i++) begin
            if (d < rows) begin
                cnt++;
                d = (d * 3) / 2;
            end
        end
        return cnt;
    endfunction

    // Level count reached by the eager schedule, found by tracking column heights.
    function automatic int early_levels(input int n);
        int h  [64];
        int nh [64];
        int cols;
        int cnt;
        int mx;
        cols = 2 * n;
        cnt  = 0;
        for (int c = 0; c < 64; c++) begin
            h[c] = 0;
            if (c < cols) h[c] = (c < n) ? c + 1 : ((2 * n - 1 - c) > 0 ? 2 * n - 1 - c : 0);
        end
        for (int lv = 0; lv < 32; lv++) begin
            mx = 0;
            for (int c = 0; c < 64; c++) if (h[c] > mx) mx = h[c];
            if (mx > 2) begin
                cnt++;
                for (int c = 0; c < 64; c++) nh[c] = 0;
                for (int c = 0; c < 63; c++) begin
                    nh[c]     += h[c] / 3 + ((h[c] % 3) != 0 ? 1 : 0);
                    nh[c + 1] += h[c] / 3 + ((h[c] % 3) == 2 ? 1 : 0);
                end
                for (int c = 0; c < 64; c++) h[c] = nh[c];
            end
        end
        return cnt;
    endfunction

endpackage

// File: rtl/mul_pp_gen.sv
module mul_pp_gen #(
    parameter int N = 7
) (
    input  logic [N-1:0]         op_a,
    input  logic [N-1:0]         op_b,
    output logic [N-1:0][N-1:0]  pp
);
    // pp[i][j] carries weight i+j.
    for (genvar i = 0; i < N; i++) begin : g_row
        for (genvar j = 0; j < N; j++) begin : g_bit
            assign pp[i][j] = op_b[i] & op_a[j];
        end
    end
endmodule

// File: rtl/mul_csa_tree.sv
module mul_csa_tree
    import mul_tree_pkg::*;
#(
    parameter int      N      = 7,
    parameter policy_e POLICY = POL_LATE
) (
    input  logic [N-1:0][N-1:0] pp,
    output logic [2*N-1:0]      row0,
    output logic [2*N-1:0]      row1
);
    localparam int COLS = 2 * N;
    localparam int MAXH = N + 2;
    localparam int LV   = late_levels(N);

    logic m [0:LV][0:COLS-1][0:MAXH-1];

    always_comb begin
        int       ht [COLS];
        int       nh [COLS];
        int       d;
        int       idx;
        int       tot;
        int       nf;
        csa_out_t r;

        for (int l = 0; l <= LV; l++)
            for (int c = 0; c < COLS; c++)
                for (int k = 0; k < MAXH; k++)
                    m[l][c][k] = 1'b0;
        for (int c = 0; c < COLS; c++) ht[c] = 0;
        r = '0;

        // Level 0: drop every partial-product bit into its column.
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                m[0][i + j][ht[i + j]] = pp[i][j];
                ht[i + j]++;
            end
        end

        for (int lv = 0; lv < LV; lv++) begin
            d = limit_at(LV - 1 - lv);
            for (int c = 0; c < COLS; c++) nh[c] = 0;
            for (int c = 0; c < COLS; c++) begin
                idx = 0;
                if (POLICY == POL_LATE) begin
                    tot = ht[c] + nh[c];
                    for (int t = 0; t < MAXH; t++) begin
                        if (tot > d) begin
                            if (tot - d == 1) begin
                                r = half_add(m[lv][c][idx], m[lv][c][idx + 1]);
                                idx += 2;
                                tot -= 1;
                            end else begin
                                r = full_add(m[lv][c][idx], m[lv][c][idx + 1], m[lv][c][idx + 2]);
                                idx += 3;
                                tot -= 2;
                            end
                            m[lv + 1][c][nh[c]] = r.sum;
                            nh[c]++;
                            if (c + 1 < COLS) begin
                                m[lv + 1][c + 1][nh[c + 1]] = r.carry;
                                nh[c + 1]++;
                            end
                        end
                    end
                end else begin
                    nf = ht[c] / 3;
                    for (int t = 0; t < MAXH; t++) begin
                        if (t < nf) begin
                            r = full_add(m[lv][c][idx], m[lv][c][idx + 1], m[lv][c][idx + 2]);
                            idx += 3;
                            m[lv + 1][c][nh[c]] = r.sum;
                            nh[c]++;
                            if (c + 1 < COLS) begin
                                m[lv + 1][c + 1][nh[c + 1]] = r.carry;
                                nh[c + 1]++;
                            end
                        end
                    end
                    if (ht[c] - idx == 2) begin
                        r = half_add(m[lv][c][idx], m[lv][c][idx + 1]);
                        idx += 2;
                        m[lv + 1][c][nh[c]] = r.sum;
                        nh[c]++;
                        if (c + 1 < COLS) begin
                            m[lv + 1][c + 1][nh[c + 1]] = r.carry;
                            nh[c + 1]++;
                        end
                    end
                end
                // Bits left untouched pass straight to the next level.
                for (int k = 0; k < MAXH; k++) begin
                    if (k >= idx && k < ht[c]) begin
                        m[lv + 1][c][nh[c]] = m[lv][c][k];
                        nh[c]++;
                    end
                end
            end
            for (int c = 0; c < COLS; c++) ht[c] = nh[c];
        end
    end

    for (genvar c = 0; c < COLS; c++) begin : g_out
        assign row0[c] = m[LV][c][0];
        assign row1[c] = m[LV][c][1];
    end
endmodule

// File: rtl/mul_cpa.sv
module mul_cpa #(
    parameter int W = 14
) (
    input  logic [W-1:0] row0,
    input  logic [W-1:0] row1,
    output logic [W-1:0] sum
);
    assign sum = row0 + row1;
endmodule

// File: rtl/mul_full_tree.sv
module mul_full_tree
    import mul_tree_pkg::*;
#(
    parameter int      N       = 7,
    parameter policy_e POLICY  = POL_LATE,
    parameter bit      REG_OUT = 1'b1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [N-1:0]   op_a,
    input  logic [N-1:0]   op_b,
    output logic [2*N-1:0] prod
);
    localparam int PW = 2 * N;

    logic [N-1:0][N-1:0] pp;
    logic [PW-1:0]       row0;
    logic [PW-1:0]       row1;
    logic [PW-1:0]       sum;

    mul_pp_gen #(.N(N)) u_pp (
        .op_a (op_a),
        .op_b (op_b),
        .pp   (pp)
    );

    mul_csa_tree #(.N(N), .POLICY(POLICY)) u_tree (
        .pp   (pp),
        .row0 (row0),
        .row1 (row1)
    );

    mul_cpa #(.W(PW)) u_cpa (
        .row0 (row0),
        .row1 (row1),
        .sum  (sum)
    );

    if (REG_OUT) begin : g_reg
        logic [PW-1:0] prod_q;
        always_ff @(posedge clk) begin
            if (rst) prod_q <= '0;
            else     prod_q <= sum;
        end
        assign prod = prod_q;
    end else begin : g_comb
        assign prod = sum;
    end
endmodule

// File: rtl/mul_full_tree_chk.sv
module mul_full_tree_chk
    import mul_tree_pkg::*;
#(
    parameter int N       = 7,
    parameter bit REG_OUT = 1'b1
) (
    input logic           clk,
    input logic           rst,
    input logic [N-1:0]   op_a,
    input logic [N-1:0]   op_b,
    input logic [2*N-1:0] prod
);
    localparam int            PW   = 2 * N;
    localparam logic [PW-1:0] MAXP = PW'(((2 ** N) - 1) * ((2 ** N) - 1));

    // R6: both schedules reach two rows in the same minimal level count
    initial begin
        a_r6_min_levels: assert (early_levels(N) == late_levels(N));
    end

    if (REG_OUT) begin : g_reg
        a_r3_one_cycle: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> prod == ({{N{1'b0}}, $past(op_a)} * {{N{1'b0}}, $past(op_b)}));

        a_r4_reset_clear: assert property (@(posedge clk)
            $past(rst) |-> prod == '0);

        a_r8_hold: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $stable(op_a) && $stable(op_b)) |=> $stable(prod));
    end else begin : g_comb
        a_r5_comb: assert property (@(posedge clk) disable iff (rst)
            prod == ({{N{1'b0}}, op_a} * {{N{1'b0}}, op_b}));
    end

    a_r7_range: assert property (@(posedge clk) disable iff (rst)
        prod <= MAXP);
endmodule

bind mul_full_tree mul_full_tree_chk #(.N(N), .REG_OUT(REG_OUT)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .op_a (op_a),
    .op_b (op_b),
    .prod (prod)
);

// File: tb/mul_full_tree_bench.sv
module mul_full_tree_bench;
    import mul_tree_pkg::*;

    localparam int N  = 7;
    localparam int PW = 2 * N;

    logic          clk;
    logic          rst;
    logic [N-1:0]  op_a;
    logic [N-1:0]  op_b;
    logic [PW-1:0] prod_late;
    logic [PW-1:0] prod_early;

    int checks;
    int failures;
    bit done;

    mul_full_tree #(.N(N), .POLICY(POL_LATE), .REG_OUT(1'b1)) u_mul_full_tree (
        .clk  (clk),
        .rst  (rst),
        .op_a (op_a),
        .op_b (op_b),
        .prod (prod_late)
    );

    mul_full_tree #(.N(N), .POLICY(POL_EARLY), .REG_OUT(1'b0)) u_mul_full_tree_early (
        .clk  (clk),
        .rst  (rst),
        .op_a (op_a),
        .op_b (op_b),
        .prod (prod_early)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    function automatic logic [PW-1:0] expect_prod(input int x, input int y);
        return PW'(x * y);
    endfunction

    task automatic check(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive on the falling edge, read both outputs just after the capturing edge.
    task automatic apply(input int x, input int y, input string tag_l, input string tag_e);
        @(negedge clk);
        op_a = N'(x);
        op_b = N'(y);
        #1;
        check(tag_e, prod_early, expect_prod(x, y));
        @(posedge clk);
        #1;
        check(tag_l, prod_late, expect_prod(x, y));
    endtask

    initial begin
        #1500000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int seed;
        logic [PW-1:0] held;
        checks   = 0;
        failures = 0;
        done     = 0;
        seed     = 32'h1f2e3d4c;
        void'($urandom(seed));
        rst  = 1'b1;
        op_a = '1;
        op_b = '1;
        repeat (3) @(posedge clk);
        #1;
        check("R4 reset", prod_late, '0);
        @(negedge clk);
        rst = 1'b0;

        // R6: both schedules need the minimal four levels for seven rows
        check("R6 late levels", PW'(late_levels(N)), PW'(4));
        check("R6 early levels", PW'(early_levels(N)), PW'(4));

        // R7 corners
        apply(0, 0, "R7 zero", "R7 zero");
        apply(0, 127, "R7 zero a", "R7 zero a");
        apply(127, 0, "R7 zero b", "R7 zero b");
        apply(1, 93, "R7 one", "R7 one");
        apply(127, 127, "R7 max", "R7 max");
        check("R7 max literal", prod_late, PW'(16129));

        // R3: new operands driven, old result held until the edge
        @(negedge clk);
        op_a = N'(45);
        op_b = N'(77);
        #1;
        check("R3 before edge", prod_late, PW'(16129));
        check("R5 comb immediate", prod_early, PW'(45 * 77));
        @(posedge clk);
        #1;
        check("R3 after edge", prod_late, PW'(45 * 77));

        // R8 hold
        held = prod_late;
        repeat (3) @(posedge clk);
        #1;
        check("R8 hold late", prod_late, held);
        check("R8 hold early", prod_early, PW'(45 * 77));

        // R4 mid-run reset
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R4 mid reset", prod_late, '0);
        @(negedge clk);
        rst = 1'b0;

        // Random mix
        for (int i = 0; i < 2000; i++) begin
            int x;
            int y;
            x = int'($urandom() % 128);
            y = int'($urandom() % 128);
            apply(x, y, "R1 random", "R2 random");
        end

        // Exhaustive sweep
        for (int x = 0; x < 128; x++) begin
            for (int y = 0; y < 128; y++) begin
                apply(x, y, "R1 sweep", "R2 sweep");
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule